// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns the output of a demodulating infrared receiver into decoded remote-control frames. The receiver line is active low: a low level is a burst of carrier (a mark), a high level is silence (a space). A two-stage prescaler divides the system clock into a base tick of (N+1) microseconds. Each part of a frame is measured in these ticks and compared against its own programmable min/max window. A frame starts with a long leader mark. A long leader space then introduces a train of data bits. A short leader space instead marks a repeat frame, which carries no data bits.

Each data bit is the time from the start of one mark to the start of the next. A short period decodes as 0 and a long one as 1. The frame ends with the mark that follows the last bit. The decoded word, a four-bit status and a one-cycle interrupt pulse are then presented on a valid/ready output. Software sets the windows, frame length, bit order, hold behaviour, enable and soft reset through a plain write port of eight word registers.

The output is a single-entry holding register. It only signals back-pressure: `out_valid` stays high until a cycle in which `out_ready` is also high, and that cycle is the read. If hold mode is off, a newly decoded event overwrites an unread result. If hold mode is on, a new event that arrives while a result is unread is discarded.

Top module: `ir_pd_decoder`

## Requirements
- R1: One tick occurs every CLKS_PER_US*(N+1) clocks, where N is bits [11:0] of register 0 (reset value 19). All windows are counted in ticks.
- R2: The leader mark must fall within register 1 (min in bits [12:0], max in bits [28:16], reset 400..500). The leader space must fall within register 2 (reset 200..300). Otherwise the frame is dropped with no interrupt.
- R3: A leader space within register 3 (reset 80..150) ends at the next mark start as a repeat event: status becomes 4'b1001 and the code is left unchanged. A leader space outside both leader-space windows drops the frame.
- R4: A bit period (mark start to next mark start) within register 4 (reset 40..72) is a 0, and one within register 5 (reset 90..134) is a 1. Any other period aborts the frame without raising valid.
- R5: When control bit 10 (logic-1 check enable, reset 1) is 0, any bit period outside the logic-0 window decodes as 1.
- R6: Control bits [4:0] hold the bit count minus one (reset 31). The frame completes at the start of the mark after the last bit. With control bit 8 = 0 the i-th received bit goes to code[i]; with it set, the bit goes to code[count-1-i]. Code bits above the count are 0.
- R7: A frame is aborted if the ticks since its leader start exceed register 6 bits [12:0] (reset 4000).
- R8: Status bit 3 means valid, bit 2 means code[31:24] is not the inverse of code[23:16], bit 1 means code[15:8] is not the inverse of code[7:0], and bit 0 means repeat. A data frame always has bit 0 clear.
- R9: `irq` is a one-cycle pulse for each accepted data frame or repeat event.
- R10: `out_valid` rises with each accepted event and falls after a cycle with `out_valid` and `out_ready` both high. That read also clears the status to 0. With hold off, a new event overwrites an unread result.
- R11: With control bit 9 (hold) set and a result unread, a new event changes neither code nor status and raises no interrupt.
- R12: Writing control with bit 16 set clears the decoder and the output (valid, code, status) to 0. Control bit 12 (enable, reset 1) at 0 ignores all line activity.
- R13: A write on `cfg_we` takes effect on the next clock. Registers 0-7 map as listed above, and every decoding setting is taken from these registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_rx_n | input | 1 | Demodulated receiver line, low = mark |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | An unread result is present |
| out_ready | input | 1 | Consumer accepts the result (read) |
| out_code | output | 32 | Decoded code word |
| out_status | output | 4 | Status nibble {valid, data err, custom err, repeat} |
| irq | output | 1 | One-cycle pulse per accepted event |

## Verification
A line edge becomes visible to the decoder after two synchronizer stages and one edge-detect register. The frame state machine registers its event one cycle later, and the output register adds one more. Code, status, valid and the interrupt therefore settle four clocks after the mark start that ends a frame. The bench checks 60 idle cycles after that trailing mark, well past the four-cycle latency. Interrupts are counted by a monitor at every edge, so a pulse is not missed between samples. A read clears the output on the edge where ready is seen, and a soft-reset write takes two edges; the bench samples after each of these settles.

// File: rtl/ir_pd_pkg.sv
package ir_pd_pkg;
  localparam int TW     = 13;
  localparam int CODE_W = 32;
  localparam int LW     = $clog2(CODE_W);
  localparam int DIVW   = 12;
  localparam int AW     = 3;
  localparam int DW     = 32;
  localparam int SW     = 4;

  localparam logic [AW-1:0] A_TICK   = 3'd0;
  localparam logic [AW-1:0] A_LMARK  = 3'd1;
  localparam logic [AW-1:0] A_LSPACE = 3'd2;
  localparam logic [AW-1:0] A_RSPACE = 3'd3;
  localparam logic [AW-1:0] A_BIT0   = 3'd4;
  localparam logic [AW-1:0] A_BIT1   = 3'd5;
  localparam logic [AW-1:0] A_FMAX   = 3'd6;
  localparam logic [AW-1:0] A_CTRL   = 3'd7;

  localparam int WIN_HI_LSB = 16;
  localparam int C_MSB  = 8;
  localparam int C_HOLD = 9;
  localparam int C_B1EN = 10;
  localparam int C_EN   = 12;
  localparam int C_SRST = 16;

  localparam int S_VALID = 3;
  localparam int S_DERR  = 2;
  localparam int S_CERR  = 1;
  localparam int S_REP   = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_LMARK, ST_LSPACE, ST_BITS} dec_state_e;

  typedef struct packed {
    logic [TW-1:0] hi;
    logic [TW-1:0] lo;
  } win_t;

  typedef struct packed {
    logic [DIVW-1:0] tick_n;
    win_t            lmark;
    win_t            lspace;
    win_t            rspace;
    win_t            bit0;
    win_t            bit1;
    logic [TW-1:0]   fmax;
    logic [LW-1:0]   len_m1;
    logic            msb;
    logic            hold;
    logic            bit1_en;
    logic            enable;
  } cfg_t;

  function automatic logic in_win(input logic [TW-1:0] v, input win_t w);
    return (v >= w.lo) && (v <= w.hi);
  endfunction
endpackage

// File: rtl/ir_pd_cfg.sv
module ir_pd_cfg
  import ir_pd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output cfg_t          cfg,
  output logic          srst
);
  win_t wr_win;
  logic wdata_unused;

  assign wr_win       = '{hi: wdata[WIN_HI_LSB +: TW], lo: wdata[0 +: TW]};
  assign wdata_unused = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.tick_n  <= DIVW'(19);
      cfg.lmark   <= '{hi: TW'(500), lo: TW'(400)};
      cfg.lspace  <= '{hi: TW'(300), lo: TW'(200)};
      cfg.rspace  <= '{hi: TW'(150), lo: TW'(80)};
      cfg.bit0    <= '{hi: TW'(72),  lo: TW'(40)};
      cfg.bit1    <= '{hi: TW'(134), lo: TW'(90)};
      cfg.fmax    <= TW'(4000);
      cfg.len_m1  <= LW'(CODE_W - 1);
      cfg.msb     <= 1'b0;
      cfg.hold    <= 1'b0;
      cfg.bit1_en <= 1'b1;
      cfg.enable  <= 1'b1;
      srst        <= 1'b0;
    end else begin
      srst <= 1'b0;
      if (we) begin
        case (addr)
          A_TICK:   cfg.tick_n <= wdata[DIVW-1:0];
          A_LMARK:  cfg.lmark  <= wr_win;
          A_LSPACE: cfg.lspace <= wr_win;
          A_RSPACE: cfg.rspace <= wr_win;
          A_BIT0:   cfg.bit0   <= wr_win;
          A_BIT1:   cfg.bit1   <= wr_win;
          A_FMAX:   cfg.fmax   <= wdata[TW-1:0];
          A_CTRL: begin
            cfg.len_m1  <= wdata[LW-1:0];
            cfg.msb     <= wdata[C_MSB];
            cfg.hold    <= wdata[C_HOLD];
            cfg.bit1_en <= wdata[C_B1EN];
            cfg.enable  <= wdata[C_EN];
            srst        <= wdata[C_SRST];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ir_pd_timebase.sv
module ir_pd_timebase
  import ir_pd_pkg::*;
#(
  parameter int CLKS_PER_US = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] tick_n,
  output logic            tick
);
  localparam int UW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [UW-1:0] US_LAST = UW'(CLKS_PER_US - 1);

  logic [UW-1:0]   us_cnt;
  logic [DIVW-1:0] t_cnt;
  logic            us_end;
  logic            t_end;

  assign us_end = (us_cnt == US_LAST);
  assign t_end  = (t_cnt >= tick_n);
  assign tick   = run && us_end && t_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_cnt <= '0;
      t_cnt  <= '0;
    end else if (!run) begin
      us_cnt <= '0;
      t_cnt  <= '0;
    end else begin
      us_cnt <= us_end ? '0 : us_cnt + 1'b1;
      if (us_end) t_cnt <= t_end ? '0 : t_cnt + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tick_n != '0) |=> (!tick || tick_n == '0)); // R1
endmodule

// File: rtl/ir_pd_edge.sv
module ir_pd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ir_n,
  output logic act_rise,
  output logic act_fall
);
  logic [2:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 3'b111;
    else        line_q <= {line_q[1:0], ir_n};
  end

  assign act_rise = !line_q[1] &&  line_q[2];
  assign act_fall =  line_q[1] && !line_q[2];
endmodule

// File: rtl/ir_pd_fsm.sv
module ir_pd_fsm
  import ir_pd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              rise,
  input  logic              fall,
  input  cfg_t              cfg,
  output logic              evt_frame,
  output logic              evt_rep,
  output logic [CODE_W-1:0] code
);
  dec_state_e    st;
  logic [TW-1:0] seg;
  logic [TW-1:0] frm;
  logic [LW-1:0] bcnt;
  logic [LW-1:0] idx;
  logic          is0, is1, bit_ok, overtime;

  always_comb begin
    is0      = in_win(seg, cfg.bit0);
    is1      = cfg.bit1_en ? in_win(seg, cfg.bit1) : 1'b1;
    bit_ok   = is0 || is1;
    idx      = cfg.msb ? (cfg.len_m1 - bcnt) : bcnt;
    overtime = (st != ST_IDLE) && (frm > cfg.fmax);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; seg <= '0; frm <= '0; bcnt <= '0; code <= '0;
      evt_frame <= 1'b0; evt_rep <= 1'b0;
    end else if (clr) begin
      st <= ST_IDLE; seg <= '0; frm <= '0; bcnt <= '0; code <= '0;
      evt_frame <= 1'b0; evt_rep <= 1'b0;
    end else begin
      evt_frame <= 1'b0;
      evt_rep   <= 1'b0;
      if (tick && seg != '1) seg <= seg + 1'b1;
      if (tick && frm != '1) frm <= frm + 1'b1;
      case (st)
        ST_IDLE: if (rise) begin
          st <= ST_LMARK; seg <= '0; frm <= '0; code <= '0;
        end
        ST_LMARK: if (fall) begin
          seg <= '0;
          st  <= in_win(seg, cfg.lmark) ? ST_LSPACE : ST_IDLE;
        end
        ST_LSPACE: if (rise) begin
          seg <= '0;
          if (in_win(seg, cfg.lspace)) begin
            st <= ST_BITS; bcnt <= '0;
          end else begin
            st <= ST_IDLE;
            if (in_win(seg, cfg.rspace)) evt_rep <= 1'b1;
          end
        end
        ST_BITS: if (rise) begin
          seg <= '0;
          if (bit_ok) begin
            code[idx] <= !is0;
            if (bcnt == cfg.len_m1) begin
              evt_frame <= 1'b1; st <= ST_IDLE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (overtime) begin
        st <= ST_IDLE; evt_frame <= 1'b0; evt_rep <= 1'b0;
      end
    end
  end

  AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (overtime && !clr) |=> (st == ST_IDLE && !evt_frame)); // R7
  AST_REP_FROM_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rep |-> $past(st) == ST_LSPACE); // R3
  AST_FRAME_FROM_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame |-> $past(st) == ST_BITS); // R6
endmodule

// File: rtl/ir_pd_decoder.sv
module ir_pd_decoder
  import ir_pd_pkg::*;
#(
  parameter int CLKS_PER_US = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_rx_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic [SW-1:0]     out_status,
  output logic              irq
);
  cfg_t              cfg;
  logic              srst, tick, rise, fall, clr;
  logic              evt_frame, evt_rep, accept, rd;
  logic              cust_err, data_err;
  logic [CODE_W-1:0] fcode;

  ir_pd_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg), .srst(srst)
  );

  ir_pd_timebase #(.CLKS_PER_US(CLKS_PER_US)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(cfg.enable && !srst),
    .tick_n(cfg.tick_n), .tick(tick)
  );

  ir_pd_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ir_n(ir_rx_n),
    .act_rise(rise), .act_fall(fall)
  );

  assign clr = srst || !cfg.enable;

  ir_pd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .rise(rise),
    .fall(fall), .cfg(cfg), .evt_frame(evt_frame), .evt_rep(evt_rep),
    .code(fcode)
  );

  assign cust_err = fcode[15:8]  != ~fcode[7:0];
  assign data_err = fcode[31:24] != ~fcode[23:16];
  assign rd       = out_valid && out_ready;
  assign accept   = (evt_frame || evt_rep) && !(cfg.hold && out_valid && !out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_code <= '0; out_status <= '0; irq <= 1'b0;
    end else if (srst) begin
      out_valid <= 1'b0; out_code <= '0; out_status <= '0; irq <= 1'b0;
    end else begin
      irq <= accept;
      if (accept) begin
        out_valid <= 1'b1;
        if (evt_frame) begin
          out_code   <= fcode;
          out_status <= {1'b1, data_err, cust_err, 1'b0};
        end else begin
          out_status <= 4'b1001;
        end
      end else if (rd) begin
        out_valid  <= 1'b0;
        out_status <= '0;
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.hold && out_valid && !out_ready && !srst) |=> ($stable(out_code) && $stable(out_status))); // R11
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !evt_frame && !evt_rep && !srst) |=> (!out_valid && out_status == '0)); // R10
  AST_VALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_status[S_VALID]); // R8
endmodule

// File: tb/test_ir_pd_decoder.sv
`timescale 1ns/1ps
module test_ir_pd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_rx_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        out_valid, out_ready = 1'b0, irq;
  logic [31:0] out_code;
  logic [3:0]  out_status;
  int          n_chk = 0, n_bad = 0, irq_seen = 0;

  always #2.5 clk = ~clk;

  ir_pd_decoder #(.CLKS_PER_US(1)) i_ir_pd_decoder (
    .clk(clk), .rst_n(rst_n), .ir_rx_n(ir_rx_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .out_status(out_status),
    .irq(irq)
  );

  always @(posedge clk) if (irq) irq_seen++;

  // tx, bit count, msb-first, expected code, expected status
  localparam logic [74:0] VEC [0:5] = '{
    {32'hFF00FF00, 6'd32, 1'b0, 32'hFF00FF00, 4'h8},
    {32'hE51A7F80, 6'd32, 1'b0, 32'hE51A7F80, 4'h8},
    {32'hA9563412, 6'd32, 1'b0, 32'hA9563412, 4'hA},
    {32'h2211F00F, 6'd32, 1'b0, 32'h2211F00F, 4'hC},
    {32'hFF00FF00, 6'd32, 1'b1, 32'h00FF00FF, 4'h8},
    {32'h0000FF00, 6'd16, 1'b0, 32'h0000FF00, 4'hC}
  };

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    idle(3);
  endtask

  function automatic logic [31:0] ctrl_w(input int len, input bit msb, input bit hold,
                                         input bit b1, input bit en, input bit srst);
    logic [31:0] w = '0;
    w[4:0] = 5'(len - 1);
    w[8] = msb; w[9] = hold; w[10] = b1; w[12] = en; w[16] = srst;
    return w;
  endfunction

  task automatic send_frame(input logic [31:0] tx, input int nbits, input int sc,
                            input int lm, input int ls, input int one_sp);
    ir_rx_n = 1'b0; idle(lm * sc);
    ir_rx_n = 1'b1; idle(ls * sc);
    for (int i = 0; i < nbits; i++) begin
      ir_rx_n = 1'b0; idle(28 * sc);
      ir_rx_n = 1'b1; idle((tx[i] ? one_sp : 28) * sc);
    end
    ir_rx_n = 1'b0; idle(28 * sc);
    ir_rx_n = 1'b1; idle(60);
  endtask

  task automatic send_ok(input logic [31:0] tx, input int nbits);
    send_frame(tx, nbits, 1, 450, 225, 84);
  endtask

  task automatic send_repeat();
    ir_rx_n = 1'b0; idle(450);
    ir_rx_n = 1'b1; idle(112);
    ir_rx_n = 1'b0; idle(28);
    ir_rx_n = 1'b1; idle(60);
  endtask

  task automatic do_read();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    chk("R12 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R12 reset status", {28'd0, out_status}, 32'd0);
    chk("R12 reset code", out_code, 32'd0);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);

    cfg_write(3'd0, 32'd0); // R13 tick every clock

    foreach (VEC[k]) begin
      logic [74:0] v = VEC[k];
      cfg_write(3'd7, ctrl_w(int'(v[42:37]), v[36], 1'b0, 1'b1, 1'b1, 1'b0));
      base = irq_seen;
      send_ok(v[74:43], int'(v[42:37]));
      chk("R6 table code", out_code, v[35:4]);
      chk("R8 table status", {28'd0, out_status}, {28'd0, v[3:0]});
      chk("R10 table valid", {31'd0, out_valid}, 32'd1);
      chk("R9 table irq count", irq_seen - base, 32'd1);
      do_read();
      chk("R10 read clears valid", {31'd0, out_valid}, 32'd0);
      chk("R10 read clears status", {28'd0, out_status}, 32'd0);
    end
    cfg_write(3'd7, ctrl_w(32, 0, 0, 1, 1, 0));

    // R3 repeat frame keeps code
    send_ok(32'hE51A7F80, 32);
    base = irq_seen;
    send_repeat();
    chk("R3 repeat status", {28'd0, out_status}, 32'h9);
    chk("R3 repeat code kept", out_code, 32'hE51A7F80);
    chk("R9 repeat irq", irq_seen - base, 32'd1);
    do_read();

    // R2 bad leader mark, bad leader space
    base = irq_seen;
    send_frame(32'hFF00FF00, 32, 1, 200, 225, 84);
    chk("R2 short leader mark dropped", {31'd0, out_valid}, 32'd0);
    send_frame(32'hFF00FF00, 32, 1, 450, 170, 84);
    chk("R3 odd leader space dropped", {31'd0, out_valid}, 32'd0);
    chk("R2 no irq on bad leader", irq_seen - base, 32'd0);

    // R4 out-of-window bit period aborts; R5 bit1 check off accepts it
    cfg_write(3'd7, ctrl_w(16, 0, 0, 1, 1, 0));
    send_frame(32'h0000FF00, 16, 1, 450, 225, 132);
    chk("R4 long bit aborts", {31'd0, out_valid}, 32'd0);
    chk("R4 no irq on abort", irq_seen - base, 32'd0);
    cfg_write(3'd7, ctrl_w(16, 0, 0, 0, 1, 0));
    send_frame(32'h0000FF00, 16, 1, 450, 225, 132);
    chk("R5 long bit as one", out_code, 32'h0000FF00);
    chk("R5 status", {28'd0, out_status}, 32'hC);
    do_read();
    cfg_write(3'd7, ctrl_w(32, 0, 0, 1, 1, 0));

    // R7 frame timeout
    cfg_write(3'd6, 32'd1000);
    base = irq_seen;
    send_ok(32'hFF00FF00, 32);
    chk("R7 timeout drops frame", {31'd0, out_valid}, 32'd0);
    chk("R7 timeout no irq", irq_seen - base, 32'd0);
    cfg_write(3'd6, 32'd4000);

    // R10 overwrite without hold
    send_ok(32'hFF00FF00, 32);
    send_ok(32'hE51A7F80, 32);
    chk("R10 overwrite code", out_code, 32'hE51A7F80);
    do_read();

    // R11 hold
    cfg_write(3'd7, ctrl_w(32, 0, 1, 1, 1, 0));
    base = irq_seen;
    send_ok(32'hFF00FF00, 32);
    send_ok(32'hE51A7F80, 32);
    chk("R11 hold keeps code", out_code, 32'hFF00FF00);
    chk("R11 hold keeps status", {28'd0, out_status}, 32'h8);
    chk("R11 hold single irq", irq_seen - base, 32'd1);
    do_read();
    send_ok(32'hE51A7F80, 32);
    chk("R11 after read new code", out_code, 32'hE51A7F80);

    // R12 soft reset
    cfg_write(3'd7, ctrl_w(32, 0, 0, 1, 1, 1));
    chk("R12 srst valid", {31'd0, out_valid}, 32'd0);
    chk("R12 srst status", {28'd0, out_status}, 32'd0);
    chk("R12 srst code", out_code, 32'd0);

    // R12 enable off
    cfg_write(3'd7, ctrl_w(32, 0, 0, 1, 0, 0));
    base = irq_seen;
    send_ok(32'hFF00FF00, 32);
    chk("R12 disabled ignores", {31'd0, out_valid}, 32'd0);
    chk("R12 disabled no irq", irq_seen - base, 32'd0);
    cfg_write(3'd7, ctrl_w(32, 0, 0, 1, 1, 0));

    // R1 tick divider N=1
    cfg_write(3'd0, 32'd1);
    send_ok(32'hFF00FF00, 32);
    chk("R1 halved ticks rejected", {31'd0, out_valid}, 32'd0);
    send_frame(32'hE51A7F80, 32, 2, 450, 225, 84);
    chk("R1 doubled timing code", out_code, 32'hE51A7F80);
    chk("R1 doubled timing status", {28'd0, out_status}, 32'h8);

    finish_run();
  end
endmodule